// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a translation that missed in the translation buffer. It takes a 32-bit effective address from one of two requesters. The top four address bits pick one of sixteen segment registers, and the 24-bit segment identifier held there is joined to the remaining 28 address bits to give a 52-bit virtual address. A hash of that virtual address selects a 64-byte group of eight two-word page-table entries in memory. The walker reads those entries one at a time and stops at the first one that matches.

If no entry in the primary group matches, the walker complements the hash to select a secondary group and searches it in the same way. A match yields a 32-bit real address along with both words of the matching entry. If both groups fail, the walker reports a page fault. A configuration origin and mask place the table in memory. Memory is reached through a plain read port that returns both words of an entry together with a valid strobe. Only one walk is in flight at a time.

Top module: `hashWalker`

## Requirements
- R1: Effective-address bits [31:28] select the segment register. Its contents at the moment of accept give the 24-bit segment ID `sid`. Writing `segWrData` to `segWrIdx` while `segWrEn` is high takes effect for requests accepted after that clock edge.
- R2: An entry matches only when all of the following hold: word0[31] is 1 (valid), word0[30:7] equals `sid`, and word0[4:0] equals effective-address bits [27:23]. An invalid entry or a mismatch in either field is skipped.
- R3: On a hit, `realAddr` = {word1[31:12], ea[11:0]}. In the same cycle, `matchWord0` and `matchWord1` carry the matching entry.
- R4: Let `vpi` = ea[27:12]. The primary hash is `sid[18:0] ^ {3'b0, vpi}`, and the secondary hash is its bitwise complement. The group index is `(hash & tblMask) | tblOrigin`. The read address for entry k is {7'b0, groupIndex, k[2:0], 3'b000}, and entries are read in order from k = 0 upward.
- R5: The search stops at the first matching entry. A hit at primary entry k costs k+1 reads, and later entries are not read.
- R6: Once all eight primary entries have failed, the walker searches the secondary group from entry 0. A hit at secondary entry k costs 9+k reads in total.
- R7: When all sixteen entries fail, `done` is raised with `fault` = 1 and `hit` = 0. Whenever `done` is high, exactly one of `hit` and `fault` is high.
- R8: A request is granted only while the walker is idle. If both requesters are valid in the same cycle, requester 0 is granted first. `doneReq` gives the index of the requester being answered.
- R9: `busy` rises in the cycle after a grant and stays high through a single-cycle `done` pulse. `busy` is low in the cycle after `done`.
- R10: After reset, `busy`, `done`, `memRdEn`, `reqGrant0` and `reqGrant1` are low while no request is valid.
- R11: At most one read is outstanding. `memRdEn` is a one-cycle pulse, and it is not asserted again until `memRdValid` has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| segWrEn | input | 1 | Segment register write strobe |
| segWrIdx | input | 4 | Segment register index |
| segWrData | input | 24 | Segment ID to write |
| tblOrigin | input | 19 | Table origin ORed into the group index |
| tblMask | input | 19 | Mask applied to the hash |
| reqValid0 | input | 1 | Requester 0 has a miss |
| reqEa0 | input | 32 | Requester 0 effective address |
| reqGrant0 | output | 1 | Requester 0 accepted at this edge |
| reqValid1 | input | 1 | Requester 1 has a miss |
| reqEa1 | input | 32 | Requester 1 effective address |
| reqGrant1 | output | 1 | Requester 1 accepted at this edge |
| memRdEn | output | 1 | Entry read request |
| memRdAddr | output | 32 | Byte address of the entry |
| memRdValid | input | 1 | Read data valid |
| memRdWord0 | input | 32 | Entry word 0 |
| memRdWord1 | input | 32 | Entry word 1 |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| doneReq | output | 1 | Requester answered by this done |
| hit | output | 1 | Translation found |
| fault | output | 1 | Page fault |
| realAddr | output | 32 | Translated real address |
| matchWord0 | output | 32 | Matching entry word 0 |
| matchWord1 | output | 32 | Matching entry word 1 |

## Verification
The walker is tried with several group layouts:
- A match at entry 0 sets the base cost.
- A group whose earlier entries each fail on one field (valid bit clear, wrong segment ID, wrong abbreviated index) shows that each field is checked separately.
- A group with two matching entries shows that the search stops at the first one.
- A primary miss followed by a secondary hit tests the retry and its complemented hash.
- An empty pair of groups forces the fault.

Every read address is compared against the expected group sequence, both under an all-ones mask and under a narrow mask with a non-zero origin. Two simultaneous requests show the fixed priority between requesters. Rewriting a segment register between walks shows that the segment ID is looked up at accept.

// File: rtl/hashWalkerPkg.sv
package hashWalkerPkg;
  parameter int EA_W        = 32;
  parameter int SID_W       = 24;
  parameter int SEG_CNT     = 16;
  parameter int SEG_IDX_W   = $clog2(SEG_CNT);
  parameter int GRP_ENTRIES = 8;
  parameter int ENT_IDX_W   = $clog2(GRP_ENTRIES);
  parameter int ENT_SHIFT   = 3;
  parameter int HASH_W      = 19;
  parameter int VPI_W       = 16;
  parameter int API_W       = 5;
  parameter int OFF_W       = 12;
  parameter int RPN_W       = EA_W - OFF_W;
  parameter int GADDR_W     = HASH_W + ENT_IDX_W + ENT_SHIFT;

  typedef struct packed {
    logic load;
    logic loadSel;
    logic advEntry;
    logic toSecondary;
    logic capture;
    logic capHit;
  } walkStrb_t;

  typedef struct packed {
    logic match;
    logic lastEntry;
    logic inSecondary;
  } walkStat_t;
endpackage

// File: rtl/hashWalkerDatapath.sv
module hashWalkerDatapath
  import hashWalkerPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 segWrEn,
  input  logic [SEG_IDX_W-1:0] segWrIdx,
  input  logic [SID_W-1:0]     segWrData,
  input  logic [HASH_W-1:0]    tblOrigin,
  input  logic [HASH_W-1:0]    tblMask,
  input  logic [EA_W-1:0]      reqEa0,
  input  logic [EA_W-1:0]      reqEa1,
  input  logic [EA_W-1:0]      memRdWord0,
  input  logic [EA_W-1:0]      memRdWord1,
  input  walkStrb_t            strb,
  output walkStat_t            stat,
  output logic [EA_W-1:0]      memRdAddr,
  output logic [EA_W-1:0]      realAddr,
  output logic [EA_W-1:0]      matchWord0,
  output logic [EA_W-1:0]      matchWord1,
  output logic                 doneReq
);
  logic [SID_W-1:0]     segFile [SEG_CNT];
  logic [EA_W-1:0]      eaReg;
  logic [SID_W-1:0]     sidReg;
  logic                 reqIdReg;
  logic [ENT_IDX_W-1:0] entryIdx;
  logic                 inSec;
  logic [EA_W-1:0]      eaSel;
  logic [VPI_W-1:0]     vpi;
  logic [API_W-1:0]     eaApi;
  logic [HASH_W-1:0]    primHash;
  logic [HASH_W-1:0]    curHash;
  logic [HASH_W-1:0]    groupIdx;
  logic [GADDR_W-1:0]   entByteAddr;
  logic                 w0Valid;
  logic [SID_W-1:0]     w0Sid;
  logic [API_W-1:0]     w0Api;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SEG_CNT; i++) segFile[i] <= '0;
    end else if (segWrEn) begin
      segFile[segWrIdx] <= segWrData;
    end
  end

  assign eaSel = strb.loadSel ? reqEa1 : reqEa0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eaReg    <= '0;
      sidReg   <= '0;
      reqIdReg <= 1'b0;
      entryIdx <= '0;
      inSec    <= 1'b0;
    end else if (strb.load) begin
      eaReg    <= eaSel;
      sidReg   <= segFile[eaSel[EA_W-1 -: SEG_IDX_W]];
      reqIdReg <= strb.loadSel;
      entryIdx <= '0;
      inSec    <= 1'b0;
    end else if (strb.toSecondary) begin
      entryIdx <= '0;
      inSec    <= 1'b1;
    end else if (strb.advEntry) begin
      entryIdx <= entryIdx + 1'b1;
    end
  end

  assign vpi         = eaReg[EA_W-SEG_IDX_W-1 -: VPI_W];
  assign eaApi       = eaReg[EA_W-SEG_IDX_W-1 -: API_W];
  assign primHash    = sidReg[HASH_W-1:0] ^ HASH_W'(vpi);
  assign curHash     = inSec ? ~primHash : primHash;
  assign groupIdx    = (curHash & tblMask) | tblOrigin;
  assign entByteAddr = {groupIdx, entryIdx, {ENT_SHIFT{1'b0}}};
  assign memRdAddr   = {{(EA_W-GADDR_W){1'b0}}, entByteAddr};

  assign w0Valid = memRdWord0[EA_W-1];
  assign w0Sid   = memRdWord0[EA_W-2 -: SID_W];
  assign w0Api   = memRdWord0[API_W-1:0];

  assign stat.match       = w0Valid && (w0Sid == sidReg) && (w0Api == eaApi);
  assign stat.lastEntry   = (entryIdx == ENT_IDX_W'(GRP_ENTRIES-1));
  assign stat.inSecondary = inSec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      realAddr   <= '0;
      matchWord0 <= '0;
      matchWord1 <= '0;
      doneReq    <= 1'b0;
    end else if (strb.capture) begin
      doneReq <= reqIdReg;
      if (strb.capHit) begin
        realAddr   <= {memRdWord1[EA_W-1 -: RPN_W], eaReg[OFF_W-1:0]};
        matchWord0 <= memRdWord0;
        matchWord1 <= memRdWord1;
      end else begin
        realAddr   <= '0;
        matchWord0 <= '0;
        matchWord1 <= '0;
      end
    end
  end

  // R6
  sec_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.toSecondary |-> (stat.lastEntry && !inSec));

  // R4
  entry_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.advEntry |=> (entryIdx != '0) && $stable(inSec));
endmodule

// File: rtl/hashWalkerControl.sv
module hashWalkerControl
  import hashWalkerPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid0,
  input  logic      reqValid1,
  input  logic      memRdValid,
  input  walkStat_t stat,
  output logic      reqGrant0,
  output logic      reqGrant1,
  output logic      memRdEn,
  output logic      busy,
  output logic      done,
  output logic      hit,
  output logic      fault,
  output walkStrb_t strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_RESP} walkState_t;
  walkState_t state, stateNext;
  logic hitReg, hitNext;

  assign reqGrant0 = (state == ST_IDLE) && reqValid0;
  assign reqGrant1 = (state == ST_IDLE) && reqValid1 && !reqValid0;

  always_comb begin
    stateNext = state;
    hitNext   = hitReg;
    strb      = '0;
    memRdEn   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (reqGrant0 || reqGrant1) begin
          strb.load    = 1'b1;
          strb.loadSel = reqGrant1;
          stateNext    = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        memRdEn   = 1'b1;
        stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRdValid) begin
          if (stat.match) begin
            strb.capture = 1'b1;
            strb.capHit  = 1'b1;
            hitNext      = 1'b1;
            stateNext    = ST_RESP;
          end else if (!stat.lastEntry) begin
            strb.advEntry = 1'b1;
            stateNext     = ST_ISSUE;
          end else if (!stat.inSecondary) begin
            strb.toSecondary = 1'b1;
            stateNext        = ST_ISSUE;
          end else begin
            strb.capture = 1'b1;
            hitNext      = 1'b0;
            stateNext    = ST_RESP;
          end
        end
      end
      ST_RESP: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      hitReg <= 1'b0;
    end else begin
      state  <= stateNext;
      hitReg <= hitNext;
    end
  end

  assign busy  = (state != ST_IDLE);
  assign done  = (state == ST_RESP);
  assign hit   = done && hitReg;
  assign fault = done && !hitReg;

  // R9
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy);

  // R9
  busy_after_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqGrant0 || reqGrant1) |=> busy);

  // R11
  single_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);

  // R7
  hit_fault_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (hit ^ fault));

  // R5
  stop_on_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && memRdValid && stat.match) |=> (done && hit));
endmodule

// File: rtl/hashWalker.sv
module hashWalker
  import hashWalkerPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 segWrEn,
  input  logic [SEG_IDX_W-1:0] segWrIdx,
  input  logic [SID_W-1:0]     segWrData,
  input  logic [HASH_W-1:0]    tblOrigin,
  input  logic [HASH_W-1:0]    tblMask,
  input  logic                 reqValid0,
  input  logic [EA_W-1:0]      reqEa0,
  output logic                 reqGrant0,
  input  logic                 reqValid1,
  input  logic [EA_W-1:0]      reqEa1,
  output logic                 reqGrant1,
  output logic                 memRdEn,
  output logic [EA_W-1:0]      memRdAddr,
  input  logic                 memRdValid,
  input  logic [EA_W-1:0]      memRdWord0,
  input  logic [EA_W-1:0]      memRdWord1,
  output logic                 busy,
  output logic                 done,
  output logic                 doneReq,
  output logic                 hit,
  output logic                 fault,
  output logic [EA_W-1:0]      realAddr,
  output logic [EA_W-1:0]      matchWord0,
  output logic [EA_W-1:0]      matchWord1
);
  walkStrb_t strb;
  walkStat_t stat;

  hashWalkerControl u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid0(reqValid0), .reqValid1(reqValid1),
    .memRdValid(memRdValid), .stat(stat),
    .reqGrant0(reqGrant0), .reqGrant1(reqGrant1),
    .memRdEn(memRdEn), .busy(busy), .done(done),
    .hit(hit), .fault(fault), .strb(strb)
  );

  hashWalkerDatapath u_dp (
    .clk(clk), .rstN(rstN),
    .segWrEn(segWrEn), .segWrIdx(segWrIdx), .segWrData(segWrData),
    .tblOrigin(tblOrigin), .tblMask(tblMask),
    .reqEa0(reqEa0), .reqEa1(reqEa1),
    .memRdWord0(memRdWord0), .memRdWord1(memRdWord1),
    .strb(strb), .stat(stat),
    .memRdAddr(memRdAddr), .realAddr(realAddr),
    .matchWord0(matchWord0), .matchWord1(matchWord1),
    .doneReq(doneReq)
  );
endmodule

// File: tb/hashWalker_bench.sv
module hashWalker_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic        segWrEn = 1'b0;
  logic [3:0]  segWrIdx = '0;
  logic [23:0] segWrData = '0;
  logic [18:0] tblOrigin = '0;
  logic [18:0] tblMask = '1;
  logic        reqValid0 = 1'b0, reqValid1 = 1'b0;
  logic [31:0] reqEa0 = '0, reqEa1 = '0;
  logic        reqGrant0, reqGrant1;
  logic        memRdEn;
  logic [31:0] memRdAddr;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdWord0 = '0, memRdWord1 = '0;
  logic        busy, done, doneReq, hit, fault;
  logic [31:0] realAddr, matchWord0, matchWord1;

  hashWalker u_hashWalker (
    .clk(clk), .rstN(rstN), .segWrEn(segWrEn), .segWrIdx(segWrIdx),
    .segWrData(segWrData), .tblOrigin(tblOrigin), .tblMask(tblMask),
    .reqValid0(reqValid0), .reqEa0(reqEa0), .reqGrant0(reqGrant0),
    .reqValid1(reqValid1), .reqEa1(reqEa1), .reqGrant1(reqGrant1),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdValid(memRdValid),
    .memRdWord0(memRdWord0), .memRdWord1(memRdWord1),
    .busy(busy), .done(done), .doneReq(doneReq), .hit(hit), .fault(fault),
    .realAddr(realAddr), .matchWord0(matchWord0), .matchWord1(matchWord1)
  );

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic        port;
    logic        isHit;
    logic [31:0] ra;
    logic [31:0] w0;
    logic [31:0] w1;
    int          nReads;
    logic [31:0] primAddr;
    logic [31:0] secAddr;
  } exp_t;

  exp_t        expQ[$];
  logic [31:0] readLog[$];
  logic [31:0] memory[logic [31:0]];
  logic [23:0] segModel[16];

  task automatic check(string req, logic ok, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] rdw(logic [31:0] a);
    return memory.exists(a) ? memory[a] : 32'h0;
  endfunction

  // Group address per R4: index = (hash & mask) | origin, shifted by 6
  function automatic logic [31:0] groupAddr(logic [23:0] sid, logic [15:0] vpi, bit sec);
    logic [18:0] h;
    h = sid[18:0] ^ {3'b000, vpi};
    if (sec) h = ~h;
    return {7'b0, (h & tblMask) | tblOrigin, 6'b0};
  endfunction

  // Entry encoding per R2 and R3
  task automatic putEntry(logic [31:0] ga, int idx, bit v, logic [23:0] sid,
                          logic [4:0] api, logic [19:0] rpn);
    memory[ga + 32'(idx*8)]     = {v, sid, 2'b00, api};
    memory[ga + 32'(idx*8) + 4] = {rpn, 12'h000};
  endtask

  function automatic exp_t model(logic port, logic [31:0] ea);
    exp_t e;
    logic [23:0] sid;
    logic [31:0] a, w0, w1;
    sid = segModel[ea[31:28]];
    e.port = port; e.isHit = 1'b0; e.ra = '0; e.w0 = '0; e.w1 = '0; e.nReads = 16;
    e.primAddr = groupAddr(sid, ea[27:12], 1'b0);
    e.secAddr  = groupAddr(sid, ea[27:12], 1'b1);
    for (int i = 0; i < 16; i++) begin
      a  = (i < 8) ? e.primAddr + 32'(i*8) : e.secAddr + 32'((i-8)*8);
      w0 = rdw(a);
      w1 = rdw(a + 4);
      if (w0[31] && w0[30:7] == sid && w0[4:0] == ea[27:23]) begin
        e.isHit = 1'b1; e.ra = {w1[31:12], ea[11:0]};
        e.w0 = w0; e.w1 = w1; e.nReads = i + 1;
        break;
      end
    end
    return e;
  endfunction

  task automatic writeSeg(int idx, logic [23:0] sid);
    @(negedge clk);
    segWrEn = 1'b1; segWrIdx = 4'(idx); segWrData = sid;
    segModel[idx] = sid;
    @(negedge clk);
    segWrEn = 1'b0;
  endtask

  task automatic driveReq(int port, logic [31:0] ea);
    @(negedge clk);
    if (port == 0) begin reqValid0 = 1'b1; reqEa0 = ea; end
    else begin reqValid1 = 1'b1; reqEa1 = ea; end
    forever begin
      #1;
      if ((port == 0 && reqGrant0) || (port == 1 && reqGrant1)) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1;
    if (port == 0) reqValid0 = 1'b0; else reqValid1 = 1'b0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (busy || expQ.size() != 0);
  endtask

  task automatic runOne(logic [31:0] ea);
    expQ.push_back(model(1'b0, ea));
    driveReq(0, ea);
    waitIdle();
  endtask

  // Bench memory: one-cycle latency read port
  always @(posedge clk) begin
    memRdValid <= memRdEn;
    if (memRdEn) begin
      memRdWord0 <= rdw(memRdAddr);
      memRdWord1 <= rdw(memRdAddr + 4);
      readLog.push_back(memRdAddr);
    end
  end

  // Monitor / scoreboard
  logic prevDone = 1'b0;
  logic afterDone = 1'b0;
  always @(negedge clk) begin
    if (afterDone) check("R9 busy low after done", !busy, {31'b0, busy}, 32'h0);
    afterDone = done;
    if (done) begin
      check("R9 done single cycle", !prevDone, {31'b0, prevDone}, 32'h0);
      check("R9 busy at done", busy, {31'b0, busy}, 32'h1);
      if (expQ.size() == 0) begin
        check("R9 unexpected done", 1'b0, 32'h1, 32'h0);
      end else begin
        exp_t e;
        int bad;
        e = expQ.pop_front();
        check("R8 doneReq order", doneReq == e.port, {31'b0, doneReq}, {31'b0, e.port});
        check("R7 hit flag", hit == e.isHit, {31'b0, hit}, {31'b0, e.isHit});
        check("R7 fault flag", fault == !e.isHit, {31'b0, fault}, {31'b0, !e.isHit});
        if (e.isHit) begin
          check("R3 realAddr", realAddr == e.ra, realAddr, e.ra);
          check("R3 matchWord0", matchWord0 == e.w0, matchWord0, e.w0);
          check("R3 matchWord1", matchWord1 == e.w1, matchWord1, e.w1);
        end
        check("R5 R6 read count", readLog.size() == e.nReads, 32'(readLog.size()), 32'(e.nReads));
        bad = 0;
        foreach (readLog[i]) begin
          logic [31:0] ex;
          ex = (i < 8) ? e.primAddr + 32'(i*8) : e.secAddr + 32'((i-8)*8);
          if (readLog[i] != ex && bad == 0) begin
            bad = 1;
            check("R4 read address sequence", 1'b0, readLog[i], ex);
          end
        end
        if (bad == 0) check("R4 read address sequence", 1'b1, 32'h0, 32'h0);
        readLog.delete();
      end
    end
    prevDone = done;
  end

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finishRun();
  end

  initial begin
    logic [31:0] ga, ea;
    for (int i = 0; i < 16; i++) segModel[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    check("R10 busy", !busy, {31'b0, busy}, 32'h0);
    check("R10 done", !done, {31'b0, done}, 32'h0);
    check("R10 memRdEn", !memRdEn, {31'b0, memRdEn}, 32'h0);
    check("R10 grants", !reqGrant0 && !reqGrant1, {30'b0, reqGrant1, reqGrant0}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    writeSeg(1, 24'hABCDE1);
    writeSeg(5, 24'h13579B);
    writeSeg(9, 24'h2468AC);
    writeSeg(14, 24'hFEDCBA);

    // R1 R3: primary entry 0 hit
    ea = 32'h1234_5678;
    ga = groupAddr(segModel[1], ea[27:12], 1'b0);
    putEntry(ga, 0, 1'b1, segModel[1], ea[27:23], 20'h0BEEF);
    runOne(ea);

    // R2: invalid, wrong sid, wrong api skipped, hit at entry 3
    ea = 32'h5ABC_D123;
    ga = groupAddr(segModel[5], ea[27:12], 1'b0);
    putEntry(ga, 0, 1'b0, segModel[5], ea[27:23], 20'h00001);
    putEntry(ga, 1, 1'b1, segModel[5] ^ 24'h000100, ea[27:23], 20'h00002);
    putEntry(ga, 2, 1'b1, segModel[5], ea[27:23] ^ 5'h01, 20'h00003);
    putEntry(ga, 3, 1'b1, segModel[5], ea[27:23], 20'h11111);
    runOne(ea);

    // R5: two matches, first wins
    ea = 32'h9876_5ABC;
    ga = groupAddr(segModel[9], ea[27:12], 1'b0);
    putEntry(ga, 2, 1'b1, segModel[9], ea[27:23], 20'h22222);
    putEntry(ga, 6, 1'b1, segModel[9], ea[27:23], 20'h66666);
    runOne(ea);

    // R6: primary miss, secondary entry 3 hit
    ea = 32'hE0F1_2345;
    ga = groupAddr(segModel[14], ea[27:12], 1'b0);
    putEntry(ga, 4, 1'b1, segModel[14], ea[27:23] ^ 5'h10, 20'h44444);
    ga = groupAddr(segModel[14], ea[27:12], 1'b1);
    putEntry(ga, 3, 1'b1, segModel[14], ea[27:23], 20'h33333);
    runOne(ea);

    // R7: fault
    runOne(32'h1FED_C0A0);

    // R8: simultaneous requests, requester 0 first
    ea = 32'h5111_1777;
    ga = groupAddr(segModel[5], ea[27:12], 1'b1);
    putEntry(ga, 0, 1'b1, segModel[5], ea[27:23], 20'h55555);
    expQ.push_back(model(1'b0, ea));
    expQ.push_back(model(1'b1, 32'h1234_5678));
    fork
      driveReq(0, ea);
      driveReq(1, 32'h1234_5678);
    join
    waitIdle();

    // R4: narrow mask with non-zero origin, hit at primary entry 7
    @(negedge clk);
    tblOrigin = 19'h12C00;
    tblMask   = 19'h003FF;
    ea = 32'h9ACE_0FFF;
    ga = groupAddr(segModel[9], ea[27:12], 1'b0);
    putEntry(ga, 7, 1'b1, segModel[9], ea[27:23], 20'h77777);
    runOne(ea);

    // R1: rewritten segment register applies to the next walk
    writeSeg(1, 24'h00F00F);
    ea = 32'h1234_5678;
    ga = groupAddr(segModel[1], ea[27:12], 1'b0);
    putEntry(ga, 1, 1'b1, segModel[1], ea[27:23], 20'h1A1A1);
    runOne(ea);

    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule